// File: doc/BRIEF.md
# Uncorrectable Error Signaling Gate

This block sits beside the error detection logic of a PCIe function and decides, for every uncorrectable error it is told about, what gets recorded and whether an error message should be requested toward the root. An error arrives as a one-cycle event carrying a one-hot error-type vector, a flag that tells fatal from non-fatal, and a flag that marks the error as an unsupported request.

Recording and signaling are handled separately. The device status summary bits and the per-type uncorrectable status bits are always updated. A message is requested only when the error type is not masked and all the reporting enables allow it. An unmasked error also asks a neighbouring logging unit to capture a header. That unit answers with an overflow indication, which the block holds. Software clears status bits through a small write-1-to-clear port.

Top module: `uncor_err_gate`

## Requirements
- R1: An event with errFatal=1 sets devStatus bit 1 (fatal detected). An event with errFatal=0 sets devStatus bit 0 (non-fatal detected). Both bits are visible in the cycle after the event.
- R2: An event with errUnsupp=1 also sets devStatus bit 2 (unsupported request detected).
- R3: Every event sets the uncorStatus bit at the position of its errType bit, whether or not that type is masked.
- R4: If errType and uncorMask overlap, no message and no logReq follow. Otherwise logReq is high for exactly the one cycle after the event.
- R5: logOvf takes the value of logOvfIn at the clock edge that ends a logReq cycle, and keeps its value at every other edge.
- R6: An unsupported-request event produces no message when urReportEn and serrEn are both 0.
- R7: A fatal event produces a message only if serrEn or fatalReportEn is 1. The message then carries msgSev=2'b10.
- R8: A non-fatal event produces a message only if serrEn or nonfatalReportEn is 1. The message then carries msgSev=2'b01.
- R9: A message appears as msgValid high for exactly the one cycle after the event.
- R10: A write with wrEn=1 clears every status bit where wrData is 1. wrSel=0 selects devStatus (wrData bits 2:0) and wrSel=1 selects uncorStatus. A hardware set in the same cycle wins over the clear.
- R11: After reset, devStatus, uncorStatus, logOvf, msgValid and logReq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | One-cycle error event strobe |
| errType | input | ERR_W | One-hot uncorrectable error type |
| errFatal | input | 1 | 1 = fatal, 0 = non-fatal |
| errUnsupp | input | 1 | Error is an unsupported request |
| uncorMask | input | ERR_W | Per-type mask register value |
| serrEn | input | 1 | Command register system-error enable |
| urReportEn | input | 1 | Unsupported-request reporting enable |
| fatalReportEn | input | 1 | Fatal reporting enable |
| nonfatalReportEn | input | 1 | Non-fatal reporting enable |
| logOvfIn | input | 1 | Overflow answer from the header logger |
| wrEn | input | 1 | Write-1-to-clear strobe |
| wrSel | input | 1 | 0 = device status, 1 = uncorrectable status |
| wrData | input | ERR_W | Bits to clear |
| devStatus | output | 3 | {UR detected, fatal detected, non-fatal detected} |
| uncorStatus | output | ERR_W | Per-type uncorrectable status |
| msgValid | output | 1 | Message request pulse |
| msgSev | output | 2 | Severity: 00 correctable, 01 non-fatal, 10 fatal |
| logReq | output | 1 | Header log request pulse |
| logOvf | output | 1 | Latched log overflow indication |

## Verification
The bench targets three mistakes. A masked error that still requests a log or a message shows up as a stray pulse. Swapping the fatal and non-fatal enables causes messages with the wrong severity to appear or go missing. An unsupported request whose only enable is the UR enable, while its severity enable is off, must stay silent, and a design that lets urReportEn alone open the gate would emit a message there. A clear arriving in the same cycle as a set of the same bit checks the priority rule: if the clear wins, the status bit reads back 0. logOvfIn is toggled outside the request window so that a design latching at the wrong edge is caught.

// File: rtl/uer_pkg.sv
package uer_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'b00,
    SEV_NONFATAL = 2'b01,
    SEV_FATAL    = 2'b10
  } sev_e;

  localparam int DEV_NF_BIT = 0;
  localparam int DEV_FE_BIT = 1;
  localparam int DEV_UR_BIT = 2;
  localparam int DEV_W      = 3;

  typedef struct packed {
    logic setNf;
    logic setFe;
    logic setUr;
    logic setUncor;
    logic reqLog;
    logic emit;
    sev_e sev;
  } strobe_t;
endpackage

// File: rtl/uer_ctrl.sv
module uer_ctrl
  import uer_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             errValid,
  input  logic [ERR_W-1:0] errType,
  input  logic             errFatal,
  input  logic             errUnsupp,
  input  logic [ERR_W-1:0] uncorMask,
  input  logic             serrEn,
  input  logic             urReportEn,
  input  logic             fatalReportEn,
  input  logic             nonfatalReportEn,
  output strobe_t          strb
);
  logic masked;
  logic urBlocked;
  logic sevAllowed;

  always_comb begin
    masked     = |(errType & uncorMask);
    urBlocked  = errUnsupp & ~urReportEn & ~serrEn;
    sevAllowed = errFatal ? (serrEn | fatalReportEn) : (serrEn | nonfatalReportEn);

    strb          = '0;
    strb.sev      = SEV_COR;
    strb.setNf    = errValid & ~errFatal;
    strb.setFe    = errValid & errFatal;
    strb.setUr    = errValid & errUnsupp;
    strb.setUncor = errValid;
    strb.reqLog   = errValid & ~masked;
    strb.emit     = errValid & ~masked & ~urBlocked & sevAllowed;
    if (strb.emit) strb.sev = errFatal ? SEV_FATAL : SEV_NONFATAL;
  end
endmodule

// File: rtl/uer_dp.sv
module uer_dp
  import uer_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [ERR_W-1:0] errType,
  input  logic             logOvfIn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [ERR_W-1:0] wrData,
  output logic [DEV_W-1:0] devStatus,
  output logic [ERR_W-1:0] uncorStatus,
  output logic             msgValid,
  output logic [1:0]       msgSev,
  output logic             logReq,
  output logic             logOvf
);
  logic [DEV_W-1:0] devSet;
  logic [DEV_W-1:0] devClr;
  logic [ERR_W-1:0] uncSet;
  logic [ERR_W-1:0] uncClr;

  always_comb begin
    devSet             = '0;
    devSet[DEV_NF_BIT] = strb.setNf;
    devSet[DEV_FE_BIT] = strb.setFe;
    devSet[DEV_UR_BIT] = strb.setUr;
    devClr             = (wrEn && !wrSel) ? wrData[DEV_W-1:0] : '0;
    uncSet             = strb.setUncor ? errType : '0;
    uncClr             = (wrEn && wrSel) ? wrData : '0;
  end

  // one write-1-to-clear cell per status bit; set wins over clear
  for (genvar i = 0; i < DEV_W; i++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rstN)          devStatus[i] <= 1'b0;
      else if (devSet[i]) devStatus[i] <= 1'b1;
      else if (devClr[i]) devStatus[i] <= 1'b0;
    end
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_unc
    always_ff @(posedge clk) begin
      if (!rstN)          uncorStatus[i] <= 1'b0;
      else if (uncSet[i]) uncorStatus[i] <= 1'b1;
      else if (uncClr[i]) uncorStatus[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgSev   <= SEV_COR;
      logReq   <= 1'b0;
      logOvf   <= 1'b0;
    end else begin
      msgValid <= strb.emit;
      msgSev   <= strb.sev;
      logReq   <= strb.reqLog;
      if (logReq) logOvf <= logOvfIn;
    end
  end
endmodule

// File: rtl/uncor_err_gate.sv
module uncor_err_gate
  import uer_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errValid,
  input  logic [ERR_W-1:0] errType,
  input  logic             errFatal,
  input  logic             errUnsupp,
  input  logic [ERR_W-1:0] uncorMask,
  input  logic             serrEn,
  input  logic             urReportEn,
  input  logic             fatalReportEn,
  input  logic             nonfatalReportEn,
  input  logic             logOvfIn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [ERR_W-1:0] wrData,
  output logic [2:0]       devStatus,
  output logic [ERR_W-1:0] uncorStatus,
  output logic             msgValid,
  output logic [1:0]       msgSev,
  output logic             logReq,
  output logic             logOvf
);
  strobe_t strb;

  uer_ctrl #(.ERR_W(ERR_W)) u_ctrl (
    .errValid(errValid), .errType(errType), .errFatal(errFatal),
    .errUnsupp(errUnsupp), .uncorMask(uncorMask), .serrEn(serrEn),
    .urReportEn(urReportEn), .fatalReportEn(fatalReportEn),
    .nonfatalReportEn(nonfatalReportEn), .strb(strb)
  );

  uer_dp #(.ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errType(errType),
    .logOvfIn(logOvfIn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .devStatus(devStatus), .uncorStatus(uncorStatus), .msgValid(msgValid),
    .msgSev(msgSev), .logReq(logReq), .logOvf(logOvf)
  );
endmodule

// File: rtl/uer_chk.sv
module uer_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             errValid,
  input logic [ERR_W-1:0] errType,
  input logic             errFatal,
  input logic             errUnsupp,
  input logic [ERR_W-1:0] uncorMask,
  input logic             serrEn,
  input logic             urReportEn,
  input logic             fatalReportEn,
  input logic             nonfatalReportEn,
  input logic             logOvfIn,
  input logic             wrEn,
  input logic             wrSel,
  input logic [ERR_W-1:0] wrData,
  input logic [2:0]       devStatus,
  input logic [ERR_W-1:0] uncorStatus,
  input logic             msgValid,
  input logic [1:0]       msgSev,
  input logic             logReq,
  input logic             logOvf
);
  p_fatal_det_r1: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errFatal) |=> devStatus[1]);

  p_ur_det_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errUnsupp) |=> devStatus[2]);

  p_uncor_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> ((uncorStatus & $past(errType)) == $past(errType)));

  p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && ((errType & uncorMask) != '0)) |=> (!logReq && !msgValid));

  p_log_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> $past(errValid));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !logReq |=> $stable(logOvf));

  p_ur_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errUnsupp && !urReportEn && !serrEn) |=> !msgValid);

  p_fatal_sev_r7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgSev == 2'b10) |-> $past(errFatal && (serrEn || fatalReportEn)));

  p_nonfatal_sev_r8: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgSev == 2'b01) |-> $past(!errFatal && (serrEn || nonfatalReportEn)));

  p_msg_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> ($past(errValid) && msgSev != 2'b00 && msgSev != 2'b11));
endmodule

bind uncor_err_gate uer_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/sim_uncor_err_gate.sv
module sim_uncor_err_gate;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errValid = 0, errFatal = 0, errUnsupp = 0;
  logic [W-1:0] errType = '0, uncorMask = '0, wrData = '0;
  logic serrEn = 0, urReportEn = 0, fatalReportEn = 0, nonfatalReportEn = 0;
  logic logOvfIn = 0, wrEn = 0, wrSel = 0;
  logic [2:0] devStatus;
  logic [W-1:0] uncorStatus;
  logic msgValid, logReq, logOvf;
  logic [1:0] msgSev;

  always #5 clk = ~clk;

  uncor_err_gate #(.ERR_W(W)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] eDev = '0;
  logic [W-1:0] eUnc = '0;
  logic eOvf = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expMsg(logic [W-1:0] t, logic [W-1:0] m, logic f,
                                  logic ur, logic se, logic ue, logic fe, logic ne);
    if ((t & m) != '0) return 1'b0;
    if (ur && !ue && !se) return 1'b0;
    return f ? (se | fe) : (se | ne);
  endfunction

  // one event, optional same-cycle clear; checks outputs after edge k and k+1
  task automatic doEvent(logic [W-1:0] t, logic [W-1:0] m, logic f, logic ur,
                         logic se, logic ue, logic fe, logic ne,
                         logic we, logic ws, logic [W-1:0] wd, string tag);
    logic em, lr, ov;
    @(negedge clk);
    errValid = 1; errType = t; uncorMask = m; errFatal = f; errUnsupp = ur;
    serrEn = se; urReportEn = ue; fatalReportEn = fe; nonfatalReportEn = ne;
    wrEn = we; wrSel = ws; wrData = wd;
    logOvfIn = $urandom;
    em = expMsg(t, m, f, ur, se, ue, fe, ne);
    lr = ((t & m) == '0);
    if (we && !ws) eDev = eDev & ~wd[2:0];
    if (we && ws)  eUnc = eUnc & ~wd;
    eDev = eDev | {ur, f, ~f};
    eUnc = eUnc | t;
    @(negedge clk);
    errValid = 0; wrEn = 0;
    chk({tag, " R9 msgValid"}, msgValid, em);
    if (em) chk({tag, f ? " R7 sev" : " R8 sev"}, msgSev, f ? 2'b10 : 2'b01);
    chk({tag, " R4 logReq"}, logReq, lr);
    chk({tag, " R1 R2 devStatus"}, devStatus, eDev);
    chk({tag, " R3 R10 uncorStatus"}, uncorStatus, eUnc);
    ov = $urandom;
    logOvfIn = ov;
    if (lr) eOvf = ov;
    @(negedge clk);
    logOvfIn = ~ov;
    chk({tag, " R5 logOvf"}, logOvf, eOvf);
    chk({tag, " R9 single pulse"}, msgValid, 1'b0);
  endtask

  task automatic doClear(logic ws, logic [W-1:0] wd);
    @(negedge clk);
    wrEn = 1; wrSel = ws; wrData = wd;
    if (ws) eUnc = eUnc & ~wd; else eDev = eDev & ~wd[2:0];
    @(negedge clk);
    wrEn = 0;
    chk("R10 clear devStatus", devStatus, eDev);
    chk("R10 clear uncorStatus", uncorStatus, eUnc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 devStatus", devStatus, 3'b000);
    chk("R11 uncorStatus", uncorStatus, '0);
    chk("R11 logOvf", logOvf, 1'b0);
    chk("R11 msgValid", msgValid, 1'b0);
    chk("R11 logReq", logReq, 1'b0);

    // directed corners
    doEvent(16'h0010, 16'h0010, 1, 1, 1, 1, 1, 1, 0, 0, '0, "masked R4");
    doEvent(16'h0002, 16'h0000, 0, 1, 0, 1, 0, 0, 0, 0, '0, "ur-only-en R6");
    doEvent(16'h0002, 16'h0000, 0, 1, 0, 0, 0, 1, 0, 0, '0, "ur-blocked R6");
    doEvent(16'h0004, 16'h0000, 1, 0, 0, 0, 1, 0, 0, 0, '0, "fatal-en R7");
    doEvent(16'h0004, 16'h0000, 1, 0, 0, 0, 0, 1, 0, 0, '0, "fatal-wrong-en R7");
    doEvent(16'h0008, 16'h0000, 0, 0, 0, 0, 1, 0, 0, 0, '0, "nf-wrong-en R8");
    doEvent(16'h0008, 16'h0000, 0, 0, 1, 0, 0, 0, 0, 0, '0, "nf-serr R8");
    doClear(1'b1, 16'hffff);
    doClear(1'b0, 16'h0007);
    doEvent(16'h0020, 16'h0000, 1, 0, 0, 0, 0, 0, 1, 1, 16'h0020, "set-vs-clr R10");
    doEvent(16'h0040, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0007, "dev-set-vs-clr R10");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] t, m;
      t = W'(1) << ($urandom % W);
      m = ($urandom % 3 == 0) ? W'($urandom) : '0;
      doEvent(t, m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
              W'($urandom), "random");
      if (n % 7 == 0) doClear(1'($urandom), W'($urandom));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule